// File: doc/BRIEF.md
# Single-Address DMA Channel

One DMA channel that carries data between memory and an external peripheral in flyby fashion. A unit moves in a single bus transaction: the channel drives a memory address and a read or write strobe, and at the same moment it acknowledges the peripheral, which drives or captures the data bus itself. The channel never holds the data. Direction, element size, address stepping, request source, acknowledge length and interrupt enable all sit in one control word.

Software writes the source address, the destination address and the unit count, then the control word, and last the global run bit. In request-driven mode the peripheral pulls its active-low request line low to get each unit. In auto mode units start as soon as the global run bit is set. When the count runs out, the channel sets a sticky done flag. Software clears that flag by writing 1 to it.

Top module: `sadma_chan`

## Requirements
- R1: After reset every register reads 0, `ack_n` is high, `mem_req` is low and `irq` is low.
- R2: Registers at offsets 0 (source), 1 (destination), 2 (count), 3 (control) and 4 (global run, bit 0) read back what was written. Control bit 1 is the done flag. Writing 1 to it clears it, and writing 0 to it leaves it unchanged. Software cannot set it.
- R3: No unit starts unless all of these hold: global run is 1, control bit 0 (channel enable) is 1, the done flag is 0, and control bits 9:8 (direction) are 01 (memory to device) or 10 (device to memory).
- R4: When control bit 3 (auto) is 0, a unit starts only after `req_n` is seen low. When it is 1, units start without `req_n`.
- R5: During a unit, `mem_req` is high and `ack_n` is low in exactly the same cycles. `mem_addr` is the source register for direction 01 and the destination register for direction 10. `mem_we` is 0 for direction 01 and 1 for direction 10. `mem_size` equals control bits 5:4.
- R6: A unit holds its strobe for at least N+1 cycles, where N is control bits 13:10. It stays asserted until `mem_rdy` is seen high.
- R7: Size codes 00, 01 and 10 mean byte, halfword and word. After each unit the source register advances by 1, 2 or 4 if control bit 6 is 1, and the destination register does the same if control bit 7 is 1. An address whose bit is 0 stays fixed.
- R8: The count register drops by one per unit. The done flag rises in the cycle after the count reaches zero. If the count is zero at start, the done flag rises on the next clock with no bus activity.
- R9: `irq` is high exactly when the done flag and control bit 2 (interrupt enable) are both 1.
- R10: While the done flag is set, no unit starts, even with channel enable and global run at 1.
- R11: Writes to the source, destination or count register are ignored while a unit is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| req_n | input | 1 | Peripheral request, active low |
| ack_n | output | 1 | Peripheral acknowledge, active low |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write memory, 0 = read memory |
| mem_size | output | 2 | Element size code |
| mem_addr | output | AW | Memory address |
| mem_rdy | input | 1 | Memory ready |

## Verification
The hardest case to reach is a register write that arrives while a unit is still holding its strobe. The ignored write and the address step then compete for the same register in a narrow window. The stimulus opens that window by programming a long acknowledge length in auto mode and writing the source register a fixed number of cycles after the run bit. A similar timed approach stretches the strobe with a late `mem_rdy`. The done-flag gate is reached by re-arming the channel without clearing the flag.

// File: rtl/sadma_chan.sv
module sadma_chan #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  input  logic          req_n,
  output logic          ack_n,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rdy
);
  localparam logic [1:0] DIR_M2D = 2'b01;
  localparam logic [1:0] DIR_D2M = 2'b10;

  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic          run_g;
  logic          c_en, c_done, c_ie, c_auto, c_sinc, c_dinc;
  logic [1:0]    c_size, c_dir;
  logic [3:0]    c_ack, hc;
  logic          busy;

  logic          dir_ok, go, fin;
  logic [AW-1:0] step;

  assign dir_ok   = (c_dir == DIR_M2D) || (c_dir == DIR_D2M);
  assign go       = run_g && c_en && !c_done && dir_ok;
  assign fin      = busy && (hc >= c_ack) && mem_rdy;
  assign step     = (c_size == 2'b00) ? AW'(1) : (c_size == 2'b01) ? AW'(2) : AW'(4);

  assign mem_req  = busy;
  assign ack_n    = !busy;
  assign mem_we   = busy && (c_dir == DIR_D2M);
  assign mem_size = c_size;
  assign mem_addr = (c_dir == DIR_D2M) ? dst : src;
  assign irq      = c_done && c_ie;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(src);
      3'd1:    reg_rdata = 32'(dst);
      3'd2:    reg_rdata = 32'(cnt);
      3'd3:    reg_rdata = {18'b0, c_ack, c_dir, c_dinc, c_sinc, c_size, c_auto, c_ie, c_done, c_en};
      3'd4:    reg_rdata = {31'b0, run_g};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; cnt <= '0; run_g <= 1'b0;
      c_en <= 1'b0; c_done <= 1'b0; c_ie <= 1'b0; c_auto <= 1'b0;
      c_sinc <= 1'b0; c_dinc <= 1'b0; c_size <= '0; c_dir <= '0; c_ack <= '0;
      hc <= '0; busy <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (!busy) src <= reg_wdata[AW-1:0];
          3'd1: if (!busy) dst <= reg_wdata[AW-1:0];
          3'd2: if (!busy) cnt <= reg_wdata[CW-1:0];
          3'd3: begin
            c_en   <= reg_wdata[0];
            if (reg_wdata[1]) c_done <= 1'b0;
            c_ie   <= reg_wdata[2];
            c_auto <= reg_wdata[3];
            c_size <= reg_wdata[5:4];
            c_sinc <= reg_wdata[6];
            c_dinc <= reg_wdata[7];
            c_dir  <= reg_wdata[9:8];
            c_ack  <= reg_wdata[13:10];
          end
          3'd4: run_g <= reg_wdata[0];
          default: ;
        endcase
      end
      if (!busy) begin
        if (go) begin
          if (cnt == '0) c_done <= 1'b1;
          else if (c_auto || !req_n) begin
            busy <= 1'b1;
            hc   <= '0;
          end
        end
      end else if (fin) begin
        busy <= 1'b0;
        cnt  <= cnt - 1'b1;
        if (c_sinc) src <= src + step;
        if (c_dinc) dst <= dst + step;
      end else if (hc < c_ack) begin
        hc <= hc + 1'b1;
      end
    end
  end

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(run_g && c_en && dir_ok));
  // R4
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(c_auto || !req_n));
  // R6
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_req) |-> ($past(mem_rdy) && ($past(hc) >= $past(c_ack))));
  // R8
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_req) |-> (cnt == $past(cnt) - 1'b1));
  // R10
  done_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_done && !mem_req) |=> !mem_req);
  // R5
  ack_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!ack_n && $stable(mem_addr) || $rose(mem_req)));
endmodule

// File: tb/sim_sadma_chan.sv
module sim_sadma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, req_n = 1'b1, ack_n, mem_req, mem_we, mem_rdy = 1'b1;
  logic [1:0] mem_size;
  logic [31:0] mem_addr;

  always #4 clk = ~clk;

  sadma_chan #(.AW(32), .CW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .req_n(req_n),
    .ack_n(ack_n), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_rdy(mem_rdy));

  int chks = 0, errs = 0;
  bit done_flag = 0;
  int units = 0, run_len = 0, exp_len = 1;
  bit in_u = 0, exp_we = 0;
  logic [31:0] exp_addr = 0, exp_step = 0;
  logic [1:0] exp_size = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      check(!ack_n, "R5 ack with strobe", ack_n, 0);
      if (!in_u) begin
        in_u = 1; run_len = 1;
        check(mem_addr == exp_addr, "R5/R7 address", mem_addr, exp_addr);
        check(mem_we == exp_we, "R5 direction", mem_we, exp_we);
        check(mem_size == exp_size, "R5 size", mem_size, exp_size);
      end else run_len++;
    end else if (rst_n) begin
      check(ack_n, "R5 ack idle", ack_n, 1);
      if (in_u) begin
        in_u = 0; units++;
        check(run_len == exp_len, "R6 strobe length", run_len, exp_len);
        exp_addr = exp_addr + exp_step;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input bit en, input bit ie, input bit au,
      input int sz, input bit si, input bit di, input int dir, input int ack);
    return 32'(en) | (32'(ie) << 2) | (32'(au) << 3) | (32'(sz) << 4) |
           (32'(si) << 6) | (32'(di) << 7) | (32'(dir) << 8) | (32'(ack) << 10);
  endfunction

  task automatic run_case(input int dir, input int sz, input int ack, input bit inc, input int n);
    logic [31:0] v, s0, d0, c;
    bit ie;
    s0 = 32'h100 + 32'(sz * 16); d0 = 32'h8000;
    ie = ack[0];
    c = mk_ctrl(1, ie, 1, sz, (dir == 1) && inc, (dir == 2) && inc, dir, ack);
    exp_addr = (dir == 1) ? s0 : d0;
    exp_step = inc ? (32'd1 << sz) : 0;
    exp_we = (dir == 2); exp_size = 2'(sz); exp_len = ack + 1; units = 0;
    wr(0, s0); wr(1, d0); wr(2, 32'(n)); wr(3, c); wr(4, 1);
    repeat (n * (ack + 2) + 6) @(negedge clk);
    check(units == n, "R8 unit count", units, n);
    rd(2, v); check(v == 0, "R8 count zero", v, 0);
    rd(0, v); check(v == ((dir == 1) ? s0 + 32'(n) * exp_step : s0), "R7 source final", v, (dir == 1) ? s0 + 32'(n) * exp_step : s0);
    rd(1, v); check(v == ((dir == 2) ? d0 + 32'(n) * exp_step : d0), "R7 destination final", v, (dir == 2) ? d0 + 32'(n) * exp_step : d0);
    rd(3, v); check(v[1] == 1, "R8 done set", v[1], 1);
    check(irq == ie, "R9 irq level", irq, ie);
    wr(4, 0); wr(3, c | 32'h2);
    rd(3, v); check(v[1] == 0, "R2 done cleared", v[1], 0);
    check(irq == 0, "R9 irq cleared", irq, 0);
  endtask

  initial begin
    logic [31:0] v;
    #1;
    check(ack_n == 1 && mem_req == 0 && irq == 0, "R1 outputs in reset", {ack_n, mem_req, irq}, 3'b100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check(v == 0, "R1 register reset", v, 0);
    end
    // R2 readback and write-1-clear
    wr(0, 32'h1234); rd(0, v); check(v == 32'h1234, "R2 source", v, 32'h1234);
    wr(1, 32'hbeef0); rd(1, v); check(v == 32'hbeef0, "R2 destination", v, 32'hbeef0);
    wr(2, 32'h77); rd(2, v); check(v == 32'h77, "R2 count", v, 32'h77);
    wr(3, 32'h3fff); rd(3, v); check(v == 32'h3ffd, "R2 control", v, 32'h3ffd);
    wr(3, 0); wr(2, 0);

    // R3 gating: each case must produce no units
    exp_len = 1; units = 0;
    wr(2, 3); wr(3, mk_ctrl(0, 0, 1, 0, 1, 0, 1, 0)); wr(4, 1);
    repeat (10) @(negedge clk); check(units == 0, "R3 channel disabled", units, 0);
    wr(3, mk_ctrl(1, 0, 1, 0, 1, 0, 0, 0));
    repeat (10) @(negedge clk); check(units == 0, "R3 direction 00", units, 0);
    wr(3, mk_ctrl(1, 0, 1, 0, 1, 0, 3, 0));
    repeat (10) @(negedge clk); check(units == 0, "R3 direction 11", units, 0);
    wr(4, 0); wr(3, mk_ctrl(1, 0, 1, 0, 1, 0, 1, 0));
    repeat (10) @(negedge clk); check(units == 0, "R3 global run off", units, 0);
    wr(3, 0);

    // R4 request-driven start
    units = 0; exp_addr = 32'h40; exp_step = 1; exp_we = 0; exp_size = 0; exp_len = 1;
    wr(0, 32'h40); wr(2, 2); wr(3, mk_ctrl(1, 0, 0, 0, 1, 0, 1, 0)); wr(4, 1);
    repeat (12) @(negedge clk); check(units == 0, "R4 waits for request", units, 0);
    req_n = 0;
    repeat (10) @(negedge clk); req_n = 1;
    check(units == 2, "R4 runs on request", units, 2);

    // R10 done flag blocks restart
    wr(4, 0); wr(2, 2); wr(3, mk_ctrl(1, 0, 1, 0, 1, 0, 1, 0)); wr(4, 1);
    units = 0; exp_addr = 32'h42;
    repeat (12) @(negedge clk); check(units == 0, "R10 blocked while done", units, 0);
    wr(3, mk_ctrl(1, 0, 1, 0, 1, 0, 1, 0) | 32'h2);
    repeat (12) @(negedge clk); check(units == 2, "R10 resumes after clear", units, 2);
    wr(4, 0); wr(3, 32'h2);

    // R8 zero-count start
    units = 0;
    wr(2, 0); wr(3, mk_ctrl(1, 1, 1, 0, 1, 0, 1, 0)); wr(4, 1);
    rd(3, v); check(v[1] == 1, "R8 zero count done next clock", v[1], 1);
    check(irq == 1, "R9 irq on zero count", irq, 1);
    repeat (5) @(negedge clk); check(units == 0, "R8 zero count no bus", units, 0);
    wr(4, 0); wr(3, 32'h2);

    // R6 stretch by mem_rdy
    units = 0; exp_addr = 32'h200; exp_step = 4; exp_we = 0; exp_size = 2; exp_len = 3;
    mem_rdy = 0;
    wr(0, 32'h200); wr(2, 1); wr(3, mk_ctrl(1, 0, 1, 2, 1, 0, 1, 0)); wr(4, 1);
    repeat (3) @(negedge clk); mem_rdy = 1;
    repeat (6) @(negedge clk); check(units == 1, "R6 stalled unit done", units, 1);
    wr(4, 0); wr(3, 32'h2);

    // R11 write while in flight is ignored
    units = 0; exp_addr = 32'h300; exp_step = 4; exp_len = 8;
    wr(0, 32'h300); wr(2, 1); wr(3, mk_ctrl(1, 0, 1, 2, 1, 0, 1, 7)); wr(4, 1);
    repeat (2) @(negedge clk);
    wr(0, 32'hdead0); wr(2, 32'h55);
    repeat (10) @(negedge clk);
    rd(0, v); check(v == 32'h304, "R11 source write ignored", v, 32'h304);
    rd(2, v); check(v == 0, "R11 count write ignored", v, 0);
    wr(4, 0); wr(3, 32'h2);

    // sweep: direction, size, ack length, stepping, count
    for (int dir = 1; dir <= 2; dir++)
      for (int sz = 0; sz < 3; sz++)
        for (int ack = 0; ack < 3; ack++)
          for (int inc = 0; inc < 2; inc++)
            for (int n = 0; n < 4; n++)
              run_case(dir, sz, ack, inc[0], n);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", chks, errs);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      chks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", chks, errs);
      $finish;
    end
  end
endmodule